// File: doc/BRIEF.md
# Video Top-of-Frame Pulse Generator

This block produces a periodic top-of-frame marker for an output video raster. It runs on the output pixel clock and keeps two counters: a pixel position within the line and a line position within the frame. The marker is held at its active level for the whole of output line zero, so it lasts one line and repeats once per output frame. The active level is chosen by a polarity input.

The block can also lock the output raster to an incoming reference raster. The reference is given as horizontal and vertical sync strobes that are already synchronous to the output clock. Locking is armed by an enable input and started by the rising edge of a control bit, or of an external pulse when that source is selected. The start reloads the counters so that the output frame begins a programmable, signed number of lines after the reference frame start. After that, and while the enable stays high, the counters are pulled back into line once per programmable number of reference frames. This lets an output rate that is a rational multiple of the input rate stay phase-locked.

Configuration is taken into internal shadow copies at an alignment start and at each natural output frame wrap. A change made while the block is running therefore never cuts a frame short.

Top module: `tof_pulse_gen`

## Requirements
- R1: After reset is released, both counters are zero and `tof_out` shows the active level at once. The active level is `cfg_pulse_pol` (1 means active high, 0 means active low).
- R2: While running freely with shadow values P pixels and L lines, `tof_out` is active for exactly P consecutive cycles out of every P×L. The active stretch starts at pixel 0 of line 0.
- R3: `tof_out` equals `cfg_pulse_pol` during line 0 and its inverse during every other line. A change of polarity shows on the output in the same cycle.
- R4: When `cfg_align_en` is 1, a rising edge of the selected init source starts an alignment. In the next cycle the pixel counter is 0, the line counter is (−offset) mod L, and both reference counters are 0. All shadows are also loaded from the configuration inputs. A source held high does not start a second alignment.
- R5: When `cfg_align_en` is 0, a rising edge of an init source has no effect on the output.
- R6: When `ext_init_sel` is 1, only `ext_init_pulse` edges start an alignment. When it is 0, only `init_req` edges do. The unselected source is ignored.
- R7: A reference frame starts on any cycle with `ref_vsync` high. It also starts on a `ref_hsync` strobe that completes the shadowed number of reference lines, counted from the last frame start; a value of 0 or 1 counts as one line. `ref_vsync` resets the reference line count.
- R8: Each reference frame start advances a frame-ratio count. When that count completes the shadowed ratio value (a value of 0 or 1 means every frame), it returns to zero. If `cfg_align_en` is 1, the output is then realigned: pixel 0, line (−offset) mod L, using the shadowed offset and L.
- R9: With `cfg_align_en` at 0, reference strobes do not alter the free-running output.
- R10: `cfg_line_offset` is two's complement. A positive value delays the output frame start by that many lines after the alignment point, and a negative value advances it. Its magnitude must be below L.
- R11: Changes to the pixel, line, reference-line, offset and ratio inputs take effect only at the next natural output frame wrap (last pixel of last line) or at an alignment start.
- R12: An alignment start takes priority over a reference frame start in the same cycle, and the reference counters are cleared. A realignment that falls on the last pixel of the frame takes priority over the wrap, and the shadows are not reloaded in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_hsync | input | 1 | Reference line strobe, one cycle, synchronous |
| ref_vsync | input | 1 | Reference frame strobe, one cycle, synchronous |
| cfg_pix_per_line | input | 13 | Output total pixels per line |
| cfg_lines_per_frame | input | 12 | Output total lines per frame |
| cfg_ref_lines | input | 12 | Reference total lines per frame |
| cfg_line_offset | input | 12 | Signed line offset of output frame start |
| cfg_rate_num | input | 13 | Reference frames between realignments |
| cfg_align_en | input | 1 | Arms alignment and periodic realignment |
| cfg_pulse_pol | input | 1 | Active level of the marker |
| init_req | input | 1 | Init control bit, acts on rising edge |
| ext_init_pulse | input | 1 | External init pulse, acts on rising edge |
| ext_init_sel | input | 1 | Selects the external pulse as init source |
| tof_out | output | 1 | Top-of-frame marker |

## Verification
Two pairs of events can land in the same cycle. The first is an init edge together with a reference frame start. The second is a ratio-triggered realignment on the last pixel of the output frame, where it competes with the shadow reload. A long mixed phase drives init edges, line strobes and frame strobes from a pseudo-random sequence against a short raster of 3 to 6 lines, so both collisions happen many times. A behavioural model in the bench applies the stated priorities, and every cycle of `tof_out` is compared with it. A wrong priority shows up as an output frame start that falls on the wrong line.

// File: rtl/tof_pkg.sv
package tof_pkg;
  parameter int PIX_W   = 13;
  parameter int LINE_W  = 12;
  parameter int RATIO_W = 13;

  typedef struct packed {
    logic [PIX_W-1:0]   ppl;
    logic [LINE_W-1:0]  lpf;
    logic [LINE_W-1:0]  ref_lpf;
    logic [LINE_W-1:0]  offset;
    logic [RATIO_W-1:0] ratio;
  } tof_cfg_t;

  // Line value loaded at an alignment point: (-offset) mod lpf, |offset| < lpf
  function automatic logic [LINE_W-1:0] start_line(input logic [LINE_W-1:0] off,
                                                   input logic [LINE_W-1:0] lpf);
    logic signed [LINE_W+1:0] n;
    logic signed [LINE_W+1:0] v;
    n = $signed({2'b00, lpf});
    v = -$signed({{2{off[LINE_W-1]}}, off});
    if (v < 0) v = v + n;
    else if (v >= n) v = v - n;
    return v[LINE_W-1:0];
  endfunction
endpackage

// File: rtl/tof_init_ctrl.sv
module tof_init_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic init_bit,
  input  logic ext_pulse,
  input  logic ext_sel,
  output logic init_evt
);
  logic bit_q, bit_d;
  logic ext_q, ext_d;
  logic bit_rise, ext_rise;

  always_comb begin
    bit_d    = init_bit;
    ext_d    = ext_pulse;
    bit_rise = init_bit & ~bit_q;
    ext_rise = ext_pulse & ~ext_q;
    init_evt = arm & (ext_sel ? ext_rise : bit_rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      ext_q <= ext_d;
    end
  end

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> (!init_evt || (ext_sel != $past(ext_sel)))); // R4
endmodule

// File: rtl/tof_ref_track.sv
module tof_ref_track
  import tof_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               hs,
  input  logic               vs,
  input  logic [LINE_W-1:0]  ref_lpf,
  input  logic [RATIO_W-1:0] ratio,
  output logic               sof,
  output logic               hit
);
  logic [LINE_W-1:0]  line_q, line_d;
  logic [RATIO_W-1:0] rcnt_q, rcnt_d;
  logic               line_last, ratio_last;

  always_comb begin
    line_last  = ({1'b0, line_q} + {{LINE_W{1'b0}}, 1'b1}) >= {1'b0, ref_lpf};
    ratio_last = ({1'b0, rcnt_q} + {{RATIO_W{1'b0}}, 1'b1}) >= {1'b0, ratio};
    sof        = vs | (hs & line_last);
    hit        = sof & ratio_last;
    line_d     = line_q;
    rcnt_d     = rcnt_q;
    if (clr) begin
      line_d = '0;
      rcnt_d = '0;
    end else begin
      if (vs)      line_d = '0;
      else if (hs) line_d = line_last ? '0 : line_q + 1'b1;
      if (sof)     rcnt_d = ratio_last ? '0 : rcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      rcnt_q <= '0;
    end else begin
      line_q <= line_d;
      rcnt_q <= rcnt_d;
    end
  end

  AST_CLR_REF: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (line_q == '0 && rcnt_q == '0)); // R12
  AST_VS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (vs && !clr) |=> (line_q == '0)); // R7
endmodule

// File: rtl/tof_out_timer.sv
module tof_out_timer
  import tof_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  tof_cfg_t           cfg_in,
  input  logic               init_evt,
  input  logic               realign,
  output logic               line_zero,
  output logic [LINE_W-1:0]  ref_lpf_s,
  output logic [RATIO_W-1:0] ratio_s
);
  tof_cfg_t          shd_q, shd_d;
  logic [PIX_W-1:0]  pix_q, pix_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              eol, eof;

  always_comb begin
    eol    = ({1'b0, pix_q} + {{PIX_W{1'b0}}, 1'b1}) >= {1'b0, shd_q.ppl};
    eof    = eol & (({1'b0, line_q} + {{LINE_W{1'b0}}, 1'b1}) >= {1'b0, shd_q.lpf});
    shd_d  = shd_q;
    pix_d  = pix_q + 1'b1;
    line_d = line_q;
    if (init_evt) begin
      shd_d  = cfg_in;
      pix_d  = '0;
      line_d = start_line(cfg_in.offset, cfg_in.lpf);
    end else if (realign) begin
      pix_d  = '0;
      line_d = start_line(shd_q.offset, shd_q.lpf);
    end else if (eol) begin
      pix_d = '0;
      if (eof) begin
        line_d = '0;
        shd_d  = cfg_in;
      end else begin
        line_d = line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= '0;
      pix_q  <= '0;
      line_q <= '0;
    end else begin
      shd_q  <= shd_d;
      pix_q  <= pix_d;
      line_q <= line_d;
    end
  end

  assign line_zero = (line_q == '0);
  assign ref_lpf_s = shd_q.ref_lpf;
  assign ratio_s   = shd_q.ratio;

  AST_PIX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_q < shd_q.ppl) || (pix_q == '0)); // R2
  AST_REALIGN_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    (realign && !init_evt) |=> (pix_q == '0)); // R8
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!eof && !init_evt) |=> $stable(shd_q)); // R11
endmodule

// File: rtl/tof_pulse_gen.sv
module tof_pulse_gen
  import tof_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_hsync,
  input  logic               ref_vsync,
  input  logic [PIX_W-1:0]   cfg_pix_per_line,
  input  logic [LINE_W-1:0]  cfg_lines_per_frame,
  input  logic [LINE_W-1:0]  cfg_ref_lines,
  input  logic [LINE_W-1:0]  cfg_line_offset,
  input  logic [RATIO_W-1:0] cfg_rate_num,
  input  logic               cfg_align_en,
  input  logic               cfg_pulse_pol,
  input  logic               init_req,
  input  logic               ext_init_pulse,
  input  logic               ext_init_sel,
  output logic               tof_out
);
  tof_cfg_t           cfg_bus;
  logic               init_evt;
  logic               ref_sof;
  logic               ratio_hit;
  logic               realign;
  logic               line_zero;
  logic [LINE_W-1:0]  ref_lpf_s;
  logic [RATIO_W-1:0] ratio_s;

  always_comb begin
    cfg_bus.ppl     = cfg_pix_per_line;
    cfg_bus.lpf     = cfg_lines_per_frame;
    cfg_bus.ref_lpf = cfg_ref_lines;
    cfg_bus.offset  = cfg_line_offset;
    cfg_bus.ratio   = cfg_rate_num;
  end

  tof_init_ctrl u_init (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (cfg_align_en),
    .init_bit  (init_req),
    .ext_pulse (ext_init_pulse),
    .ext_sel   (ext_init_sel),
    .init_evt  (init_evt)
  );

  tof_ref_track u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (init_evt),
    .hs      (ref_hsync),
    .vs      (ref_vsync),
    .ref_lpf (ref_lpf_s),
    .ratio   (ratio_s),
    .sof     (ref_sof),
    .hit     (ratio_hit)
  );

  assign realign = ratio_hit & cfg_align_en;

  tof_out_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_in    (cfg_bus),
    .init_evt  (init_evt),
    .realign   (realign),
    .line_zero (line_zero),
    .ref_lpf_s (ref_lpf_s),
    .ratio_s   (ratio_s)
  );

  assign tof_out = cfg_pulse_pol ? line_zero : ~line_zero;

  AST_HIT_NEEDS_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_hit |-> (ref_vsync || ref_hsync)); // R7
endmodule

// File: tb/test_tof_pulse_gen.sv
`timescale 1ns/1ps
module test_tof_pulse_gen;
  logic clk = 1'b0;
  logic rst_n;
  logic ref_hsync, ref_vsync;
  logic [12:0] cfg_pix_per_line;
  logic [11:0] cfg_lines_per_frame, cfg_ref_lines, cfg_line_offset;
  logic [12:0] cfg_rate_num;
  logic cfg_align_en, cfg_pulse_pol, init_req, ext_init_pulse, ext_init_sel;
  logic tof_out;

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  tof_pulse_gen i_tof_pulse_gen (
    .clk(clk), .rst_n(rst_n), .ref_hsync(ref_hsync), .ref_vsync(ref_vsync),
    .cfg_pix_per_line(cfg_pix_per_line), .cfg_lines_per_frame(cfg_lines_per_frame),
    .cfg_ref_lines(cfg_ref_lines), .cfg_line_offset(cfg_line_offset),
    .cfg_rate_num(cfg_rate_num), .cfg_align_en(cfg_align_en),
    .cfg_pulse_pol(cfg_pulse_pol), .init_req(init_req),
    .ext_init_pulse(ext_init_pulse), .ext_init_sel(ext_init_sel), .tof_out(tof_out)
  );

  // behavioural reference model
  int m_pix, m_line, m_rline, m_rcnt;
  int s_ppl, s_lpf, s_rlpf, s_off, s_ratio;
  bit m_bit_q, m_ext_q;

  function automatic int sgn12(input logic [11:0] v);
    return v[11] ? int'(v) - 4096 : int'(v);
  endfunction
  function automatic int first_line(input int off, input int lpf);
    if (lpf <= 0) return 0;
    return ((-off % lpf) + lpf) % lpf;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pix = 0; m_line = 0; m_rline = 0; m_rcnt = 0;
      s_ppl = 0; s_lpf = 0; s_rlpf = 0; s_off = 0; s_ratio = 0;
      m_bit_q = 0; m_ext_q = 0;
    end else begin
      bit edge_seen, start, sof, hit;
      edge_seen = ext_init_sel ? (ext_init_pulse && !m_ext_q) : (init_req && !m_bit_q);
      start = edge_seen && cfg_align_en;
      m_bit_q = init_req; m_ext_q = ext_init_pulse;
      if (start) begin
        s_ppl = cfg_pix_per_line; s_lpf = cfg_lines_per_frame; s_rlpf = cfg_ref_lines;
        s_off = sgn12(cfg_line_offset); s_ratio = cfg_rate_num;
        m_pix = 0; m_line = first_line(s_off, s_lpf); m_rline = 0; m_rcnt = 0;
      end else begin
        sof = ref_vsync || (ref_hsync && (m_rline + 1 >= s_rlpf));
        if (ref_vsync) m_rline = 0;
        else if (ref_hsync) m_rline = (m_rline + 1 >= s_rlpf) ? 0 : m_rline + 1;
        hit = 0;
        if (sof) begin
          if (m_rcnt + 1 >= s_ratio) begin hit = 1; m_rcnt = 0; end
          else m_rcnt = m_rcnt + 1;
        end
        if (hit && cfg_align_en) begin
          m_pix = 0; m_line = first_line(s_off, s_lpf);
        end else if (m_pix + 1 >= s_ppl) begin
          m_pix = 0;
          if (m_line + 1 >= s_lpf) begin
            m_line = 0;
            s_ppl = cfg_pix_per_line; s_lpf = cfg_lines_per_frame; s_rlpf = cfg_ref_lines;
            s_off = sgn12(cfg_line_offset); s_ratio = cfg_rate_num;
          end else m_line = m_line + 1;
        end else m_pix = m_pix + 1;
      end
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("[TB] FAIL %s: tof_out=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always begin
    @(negedge clk); #1;
    if (rst_n && !done) check(tof_out, (m_line == 0) ? cfg_pulse_pol : ~cfg_pulse_pol, cur_req);
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ref_run(input int n, input int hper, input int vs_every, input bit use_vs);
    int hc = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      ref_hsync = (c % hper == 0);
      ref_vsync = 1'b0;
      if (ref_hsync) begin
        ref_vsync = use_vs && (hc % vs_every == 0);
        hc++;
      end
    end
    @(negedge clk);
    ref_hsync = 0; ref_vsync = 0;
  endtask

  initial begin
    rst_n = 0; ref_hsync = 0; ref_vsync = 0;
    cfg_pix_per_line = 5; cfg_lines_per_frame = 4; cfg_ref_lines = 3;
    cfg_line_offset = 0; cfg_rate_num = 1; cfg_align_en = 0; cfg_pulse_pol = 1;
    init_req = 0; ext_init_pulse = 0; ext_init_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(tof_out, 1'b1, "R1");            // R1 active level straight after reset
    cur_req = "R2"; run(60);               // R2 free-running period
    cur_req = "R3";                        // R3 polarity flip
    @(negedge clk); cfg_pulse_pol = 0; run(40);
    @(negedge clk); cfg_pulse_pol = 1;
    cur_req = "R11";                       // R11 change mid-frame
    run(7); cfg_pix_per_line = 7; cfg_lines_per_frame = 3; run(70);
    cur_req = "R5";                        // R5 init ignored when disarmed
    init_req = 1; run(30); init_req = 0; run(5);
    cur_req = "R9";                        // R9 reference ignored when disarmed
    ref_run(90, 4, 3, 1);
    cur_req = "R4";                        // R4 init alignment, held bit no retrigger
    cfg_align_en = 1; run(3); cfg_line_offset = 1; init_req = 1; run(50);
    cur_req = "R10";                       // R10 negative offset advances
    init_req = 0; cfg_line_offset = 12'hFFF; run(2); init_req = 1; run(50);
    init_req = 0; cfg_line_offset = 2; run(2); init_req = 1; run(40); init_req = 0;
    cur_req = "R6";                        // R6 source selection
    ext_init_sel = 1; cfg_line_offset = 0; run(9); init_req = 1; run(25);
    ext_init_pulse = 1; run(1); ext_init_pulse = 0; run(30);
    ext_init_sel = 0; run(11); ext_init_pulse = 1; run(1); ext_init_pulse = 0; run(25);
    cur_req = "R8";                        // R8 ratio-controlled realignment
    cfg_rate_num = 2; init_req = 0; run(1); init_req = 1; run(3); init_req = 0;
    ref_run(200, 6, 3, 1);
    cfg_rate_num = 0; ref_run(120, 5, 2, 1);
    cur_req = "R7";                        // R7 frame start from line count only
    cfg_rate_num = 3; cfg_ref_lines = 4; run(25);
    ref_run(220, 4, 1, 0);
    cur_req = "R12";                       // R12 collisions, pseudo-random
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 4000; k++) begin
        @(negedge clk);
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        ref_hsync = lf[0] & lf[3];
        ref_vsync = lf[0] & lf[3] & lf[5] & lf[7];
        init_req  = lf[9] & lf[2];
        ext_init_pulse = lf[11];
        if (lf[15:10] == 6'd5) ext_init_sel = ~ext_init_sel;
        if (lf[15:10] == 6'd9) cfg_align_en = ~cfg_align_en;
        if (lf[15:11] == 5'd3) begin
          cfg_lines_per_frame = 12'(3 + (lf[4:2] % 4));
          cfg_pix_per_line = 13'(2 + lf[6:5]);
          cfg_line_offset = 12'(int'(lf[8:7]) - 1);
          cfg_rate_num = 13'(lf[1:0]);
          cfg_ref_lines = 12'(1 + lf[3:2]);
        end
      end
      ref_hsync = 0; ref_vsync = 0; init_req = 0; ext_init_pulse = 0;
    end
    run(20);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("[TB] FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule